// File: doc/BRIEF.md
# Boundary-Scan Shift Engine with Three-Valued TDO Compare

This block runs one complete scan shift on a test access port. The port must already sit in its data-shift or instruction-shift state when the shift starts. A request supplies a vector of up to `MAX_LEN` bits, a bit count, a two-bit expectation code for every bit, and a global compare enable.

The engine generates the test clock from the system clock. It drives one bit per test-clock period, least significant bit first. The mode-select line stays low until the final bit. On the final bit the line goes high, so the port leaves the shift state and stops in its exit-1 state, and the following cycle shifts no stray bit. The engine samples each returned bit on the rising test-clock edge and checks it against its expectation.

At the end of the shift the engine pulses `done`. It then holds the following results until the next accepted request:
- the captured vector;
- a per-bit mismatch mask;
- an overall fail flag.

A request with an illegal length is refused with a one-cycle error pulse, and the test clock does not move.

Top module: `scan_shift_engine`

## Requirements
- R1: While idle, `busy`, `tck`, `tms` and `tdi` are all low.
- R2: `tdi` presents `tdi_vec` least significant bit first, one bit per test-clock period, with exactly `len` rising `tck` edges per accepted request.
- R3: `tms` is 0 at the rising `tck` edges of bits 0 to `len`-2 and 1 at the rising edge of the last bit, so a port starting in a shift state ends in exit-1. `tdi` and `tms` change only while `tck` is low.
- R4: `tdo` is sampled at each rising `tck` edge. Bit i of `cap_vec` holds sample i, and bits at or above `len` read 0.
- R5: The code for bit i sits in `exp_code[2i+1:2i]`: 01 expects 0, 10 expects 1, and 00 or 11 means don't-care. `miss_mask` bit i is set when a sample contradicts its code, and `fail` is the OR of the mask.
- R6: With `cmp_en` low at the request, capture still takes place, but `miss_mask` is all zero and `fail` is low.
- R7: A request with `len` equal to 0 or above `MAX_LEN` raises `len_err` for one cycle on the next clock. It produces no `tck` edge and leaves `busy` low.
- R8: `done` pulses for one cycle exactly 2*`len`*`TCK_HALF` clock cycles after the edge that accepts the request. The results stay stable until the next accepted request.
- R9: `start` is ignored while `busy` is high. A running shift is unaffected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| len | input | $clog2(MAX_LEN+1) | Number of bits to shift |
| tdi_vec | input | MAX_LEN | Data to shift out, bit 0 first |
| exp_code | input | 2*MAX_LEN | Two-bit expectation per bit position |
| cmp_en | input | 1 | Global compare enable |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the port |
| tdo | input | 1 | Test data from the port |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle end-of-shift pulse |
| len_err | output | 1 | One-cycle illegal-length pulse |
| cap_vec | output | MAX_LEN | Captured TDO bits |
| miss_mask | output | MAX_LEN | Per-bit mismatch flags |
| fail | output | 1 | Any mismatch |

## Verification
A legal request takes 2*`len`*`TCK_HALF` clock cycles before `done`, and an illegal one raises `len_err` on the clock right after acceptance. The bench counts falling system-clock edges from the accepting edge and compares that count with the formula. It reads the captured vector, mask and fail flag only in the cycle where `done` is seen.

The bench records the per-bit `tdi` and `tms` values at each rising `tck`, so every bit is checked at the instant the port would latch it. A model of the port tracks its state and confirms that the shift ends in exit-1. The model drives `tdo` on falling `tck`, so each sample is stable for a full half period before the engine reads it.

// File: rtl/sse_pkg.sv
package sse_pkg;
   typedef enum logic [1:0] {
      CODE_ANY  = 2'b00,
      CODE_LOW  = 2'b01,
      CODE_HIGH = 2'b10,
      CODE_ANY2 = 2'b11
   } exp_code_e;

   function automatic logic code_mismatch(input logic [1:0] code, input logic val);
      case (code)
         CODE_LOW:  code_mismatch = val;
         CODE_HIGH: code_mismatch = ~val;
         default:   code_mismatch = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/sse_tck_div.sv
module sse_tck_div #(
   parameter int TCK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   initial assert (TCK_HALF >= 1) else $fatal(1, "TCK_HALF must be at least 1");

   generate
      if (TCK_HALF == 1) begin : g_fast
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(TCK_HALF);
         logic [CW-1:0] cnt_q;
         assign tick = run && (cnt_q == CW'(TCK_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (!run)    cnt_q <= '0;
            else if (tick)    cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sse_cmp_array.sv
module sse_cmp_array
   import sse_pkg::*;
#(
   parameter int MAX_LEN = 32
) (
   input  logic [2*MAX_LEN-1:0] codes,
   input  logic [MAX_LEN-1:0]   samples,
   input  logic                 enable,
   output logic [MAX_LEN-1:0]   miss
);
   generate
      for (genvar i = 0; i < MAX_LEN; i++) begin : g_bit
         assign miss[i] = enable && code_mismatch(codes[2*i +: 2], samples[i]);
      end
   endgenerate
endmodule

// File: rtl/scan_shift_engine.sv
module scan_shift_engine
   import sse_pkg::*;
#(
   parameter int MAX_LEN  = 32,
   parameter int TCK_HALF = 2,
   localparam int LW      = $clog2(MAX_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [LW-1:0]        len,
   input  logic [MAX_LEN-1:0]   tdi_vec,
   input  logic [2*MAX_LEN-1:0] exp_code,
   input  logic                 cmp_en,
   output logic                 tck,
   output logic                 tms,
   output logic                 tdi,
   input  logic                 tdo,
   output logic                 busy,
   output logic                 done,
   output logic                 len_err,
   output logic [MAX_LEN-1:0]   cap_vec,
   output logic [MAX_LEN-1:0]   miss_mask,
   output logic                 fail
);
   initial assert (MAX_LEN >= 1) else $fatal(1, "MAX_LEN must be at least 1");

   logic                 busy_q, done_q, err_q;
   logic                 tck_q, tms_q, tdi_q, cmp_q;
   logic [LW-1:0]        idx_q, last_q;
   logic [MAX_LEN-1:0]   pend_q, cap_q;
   logic [2*MAX_LEN-1:0] code_q;
   logic                 tick;
   logic                 len_bad, accept, reject;

   assign len_bad = (len == '0) || (len > LW'(MAX_LEN));
   assign accept  = start && !busy_q && !len_bad;
   assign reject  = start && !busy_q && len_bad;

   sse_tck_div #(.TCK_HALF(TCK_HALF)) div_i (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         tck_q  <= 1'b0;
         tms_q  <= 1'b0;
         tdi_q  <= 1'b0;
         cmp_q  <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         pend_q <= '0;
         cap_q  <= '0;
         code_q <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= reject;
         if (accept) begin
            busy_q <= 1'b1;
            tck_q  <= 1'b0;
            idx_q  <= '0;
            last_q <= len - 1'b1;
            tdi_q  <= tdi_vec[0];
            tms_q  <= (len == LW'(1));
            pend_q <= tdi_vec >> 1;
            cap_q  <= '0;
            cmp_q  <= cmp_en;
            for (int i = 0; i < MAX_LEN; i++)
               code_q[2*i +: 2] <= (i < int'(len)) ? exp_code[2*i +: 2] : CODE_ANY;
         end else if (busy_q && tick) begin
            if (!tck_q) begin
               tck_q        <= 1'b1;
               cap_q[idx_q] <= tdo;
            end else begin
               tck_q <= 1'b0;
               if (idx_q == last_q) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  tms_q  <= 1'b0;
                  tdi_q  <= 1'b0;
               end else begin
                  idx_q  <= idx_q + 1'b1;
                  tdi_q  <= pend_q[0];
                  pend_q <= pend_q >> 1;
                  tms_q  <= (idx_q + 1'b1 == last_q);
               end
            end
         end
      end
   end

   sse_cmp_array #(.MAX_LEN(MAX_LEN)) cmp_i (
      .codes  (code_q),
      .samples(cap_q),
      .enable (cmp_q),
      .miss   (miss_mask)
   );

   assign tck     = tck_q;
   assign tms     = tms_q;
   assign tdi     = tdi_q;
   assign busy    = busy_q;
   assign done    = done_q;
   assign len_err = err_q;
   assign cap_vec = cap_q;
   assign fail    = |miss_mask;
endmodule

// File: rtl/sse_checker.sv
module sse_checker #(
   parameter int MAX_LEN = 32,
   localparam int LW     = $clog2(MAX_LEN + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [LW-1:0] len,
   input logic          tck,
   input logic          tms,
   input logic          tdi,
   input logic          busy,
   input logic          done,
   input logic          len_err
);
   // R1: idle port lines are quiet
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!tck && !tms && !tdi));

   // R3: data and mode lines hold while the test clock is high
   a_r3_stable_when_high: assert property (@(posedge clk) disable iff (!rst_n)
      (tck && $past(tck)) |-> ($stable(tdi) && $stable(tms)));

   // R7: illegal length is refused without starting
   a_r7_bad_len_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (len == '0)) |=> (len_err && !busy));

   // R8: done ends a busy period
   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8: done and error never coincide
   a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, len_err}));
endmodule

bind scan_shift_engine sse_checker #(.MAX_LEN(MAX_LEN)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .len    (len),
   .tck    (tck),
   .tms    (tms),
   .tdi    (tdi),
   .busy   (busy),
   .done   (done),
   .len_err(len_err)
);

// File: tb/scan_shift_engine_tb.sv
module scan_shift_engine_tb_top;
   localparam int MAX  = 32;
   localparam int HALF = 2;
   localparam int LW   = $clog2(MAX + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, cmp_en = 1'b0, tdo = 1'b0;
   logic [LW-1:0] len = '0;
   logic [MAX-1:0] tdi_vec = '0;
   logic [2*MAX-1:0] exp_code = '0;
   logic tck, tms, tdi, busy, done, len_err, fail;
   logic [MAX-1:0] cap_vec, miss_mask;

   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   scan_shift_engine #(.MAX_LEN(MAX), .TCK_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .len(len), .tdi_vec(tdi_vec),
      .exp_code(exp_code), .cmp_en(cmp_en), .tck(tck), .tms(tms), .tdi(tdi),
      .tdo(tdo), .busy(busy), .done(done), .len_err(len_err), .cap_vec(cap_vec),
      .miss_mask(miss_mask), .fail(fail)
   );

   // port model: records lines at rising tck, drives tdo at falling tck
   logic [MAX-1:0] seen_tdi, seen_tms, r_resp;
   int rises, k, tap_st; // 0 shift, 1 exit1, 2 past exit1

   always @(posedge tck) begin
      if (rises < MAX) begin
         seen_tdi[rises] = tdi;
         seen_tms[rises] = tms;
      end
      rises = rises + 1;
      if (tap_st == 0) begin
         if (tms) tap_st = 1;
      end else tap_st = 2;
   end

   always @(negedge tck) begin
      k = k + 1;
      tdo = (k < MAX) ? r_resp[k] : 1'b0;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input int n, input logic [MAX-1:0] vec, input logic [2*MAX-1:0] code,
                      input logic [MAX-1:0] resp, input bit cmp, input bit poke);
      int cnt;
      bit bad;
      logic [MAX-1:0] e_cap, e_miss, e_tms, vmask;
      bad = (n == 0) || (n > MAX);
      @(negedge clk);
      len = LW'(n); tdi_vec = vec; exp_code = code; cmp_en = cmp;
      r_resp = resp; k = 0; rises = 0; tap_st = 0; tdo = resp[0];
      seen_tdi = '0; seen_tms = '0;
      start = 1'b1;
      cnt = 0;
      while (1) begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) start = 1'b0;
         if (poke && cnt == 4) begin start = 1'b1; len = LW'(1); tdi_vec = ~vec; end
         if (poke && cnt == 5) start = 1'b0;
         if (done || len_err || cnt > 4*MAX*HALF + 20) break;
      end
      if (bad) begin
         chk(len_err && cnt == 1, "R7 error pulse timing", 64'(cnt), 64'd1);
         chk(!busy && rises == 0, "R7 no tck activity", 64'(rises), 64'd0);
         @(negedge clk);
         chk(!len_err, "R7 error one cycle", 64'(len_err), 64'd0);
      end else begin
         vmask = (n >= MAX) ? '1 : ((MAX'(1) << n) - 1'b1);
         e_cap = resp & vmask;
         e_miss = '0;
         for (int i = 0; i < n; i++)
            if (cmp && ((code[2*i +: 2] == 2'b01 && resp[i]) || (code[2*i +: 2] == 2'b10 && !resp[i])))
               e_miss[i] = 1'b1;
         e_tms = MAX'(1) << (n - 1);
         chk(done && cnt == 2*n*HALF + 1, "R8 done latency", 64'(cnt), 64'(2*n*HALF + 1));
         chk(rises == n, "R2 rising edge count", 64'(rises), 64'(n));
         chk((seen_tdi & vmask) == (vec & vmask), "R2 tdi order", 64'(seen_tdi), 64'(vec & vmask));
         chk(seen_tms == e_tms, "R3 tms pattern", 64'(seen_tms), 64'(e_tms));
         chk(tap_st == 1, "R3 ends in exit1", 64'(tap_st), 64'd1);
         chk(cap_vec == e_cap, "R4 captured vector", 64'(cap_vec), 64'(e_cap));
         chk(miss_mask == e_miss, cmp ? "R5 mismatch mask" : "R6 mask with compare off",
             64'(miss_mask), 64'(e_miss));
         chk(fail == (e_miss != 0), cmp ? "R5 fail flag" : "R6 fail with compare off",
             64'(fail), 64'(e_miss != 0));
         chk(!tck && !tms && !tdi && !busy, "R1 quiet after done", {tck, tms, tdi, busy}, 64'd0);
         @(negedge clk);
         chk(!done && cap_vec == e_cap, "R8 one-cycle done, results held", 64'(cap_vec), 64'(e_cap));
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [MAX-1:0] v, r;
      logic [2*MAX-1:0] c;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!tck && !tms && !tdi && !busy && !done && !len_err && cap_vec == 0,
          "R1 reset state", {tck, tms, tdi, busy, done, len_err}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tck && !busy, "R1 idle after reset", {tck, busy}, 64'd0);
      // single bit: tms high on the only bit
      run(1, 32'h1, 64'h2, 32'h1, 1'b1, 1'b0);
      // full length, all low expectations against alternating data
      run(MAX, 32'hA5A5_0F0F, {MAX{2'b01}}, 32'h0000_FFFF, 1'b1, 1'b0);
      // all high expectations, matching data: no failure
      run(8, 32'h3C, {MAX{2'b10}}, 32'hFF, 1'b1, 1'b0);
      // don't-care codes 00 and 11 never mismatch
      run(16, 32'h1234, {16'h0, {8{4'b1100}}}, 32'h5A5A, 1'b1, 1'b0);
      // compare disabled with contradicting data
      run(12, 32'hABC, {MAX{2'b10}}, 32'h0, 1'b0, 1'b0);
      // illegal lengths
      run(0, 32'hFFFF, 64'h0, 32'h0, 1'b1, 1'b0);
      run(MAX + 1, 32'hFFFF, 64'h0, 32'h0, 1'b1, 1'b0);
      // start during busy is ignored (R9)
      run(6, 32'h2D, {MAX{2'b01}}, 32'h15, 1'b1, 1'b1);
      // random requests
      for (int t = 0; t < 24; t++) begin
         v = $urandom;
         r = $urandom;
         c = {$urandom, $urandom};
         run(1 + int'($urandom % MAX), v, c, r, ($urandom % 4) != 0, t % 5 == 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule